// File: doc/BRIEF.md
# Four-Way Read Cache with Tree Pseudo-LRU Replacement

This block is a read-only, set-associative cache for a processor load path. It holds lines of 32 bytes in four ways per set, with the set count as a parameter. A load is presented as a valid flag and a byte address. On a hit the requested 32-bit word returns one cycle later. On a miss the block stalls its request side, fetches the whole line from memory as eight 32-bit beats, installs it, and then returns the requested word marked as a miss.

When a set is full, the line to evict is chosen by three binary-tree bits kept per set. These bits approximate least-recently-used order at a fraction of the cost of exact ordering. Empty ways are always used before any valid line is displaced. Stores, coherence and address translation are not handled here.

Top module: `rd_cache_4w`

## Requirements
- R1: After reset every line is invalid and every tree bit is zero: req_ready_o is 1, rsp_valid_o and mem_req_o are 0, and the first load to any address misses.
- R2: The address splits as follows. Bits [4:0] are the byte offset and bits [4:2] pick one of the 8 words in the line. The next log2(SETS) bits are the set index, and the remaining upper bits are the tag.
- R3: A load accepted (req_valid_i high while req_ready_o is high) that hits gives, in the next cycle, a single-cycle rsp_valid_o pulse with rsp_hit_o = 1 and the addressed word, and it raises no memory request.
- R4: A load that misses raises mem_req_o in the next cycle, with mem_line_addr_o equal to the load address with bits [4:0] cleared. req_ready_o stays low until the miss completes.
- R5: While mem_req_o is high, each cycle with mem_beat_valid_i high takes one beat, in word order 0 to 7, and idle cycles between beats are allowed. In the cycle after the eighth beat, mem_req_o is low and rsp_valid_o pulses once with rsp_hit_o = 0 and the addressed word.
- R6: On a miss, if any way of the set is invalid, the lowest-numbered invalid way receives the line.
- R7: Each set keeps tree bits t0, t1 and t2. When every way is valid, the victim is way 0 or 1 (chosen by t1 = 0 or 1) if t0 = 0, and way 2 or 3 (chosen by t2) if t0 = 1. A hit or fill of way w sets t0 = not w[1]. It also sets t1 = not w[0] when w < 2, or t2 = not w[0] when w >= 2.
- R8: Sets are independent. A line with the same tag in another set neither hits nor changes the replacement state of this set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_addr_i | input | ADDR_W | Load byte address |
| req_ready_o | output | 1 | Block can accept a load (low while a miss is in progress) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Response was a hit (1) or a completed miss (0) |
| rsp_data_o | output | 32 | Addressed word |
| mem_req_o | output | 1 | Line fetch in progress |
| mem_line_addr_o | output | ADDR_W | Line-aligned fetch address |
| mem_beat_valid_i | input | 1 | Fill beat valid |
| mem_beat_data_i | input | 32 | Fill beat data, word 0 first |

## Verification
Loads are driven against a behavioural model that tracks valid, tag and tree state per set. Four distinct tags fill one set, which separates the empty-way order (R6) from tree-driven eviction (R7). Reordered hits followed by a fifth tag then show whether the tree points away from recently used ways. The same tag in a second set exposes any leak of state between sets (R8). Fills with idle gaps between beats, and words taken from both ends and the middle of the line, show whether the returned word is aligned correctly whatever the beat timing.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  localparam int WAYS       = 4;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int WORD_W     = 32;
  localparam int LINE_BYTES = 32;
  localparam int LINE_WORDS = LINE_BYTES / (WORD_W / 8);
  localparam int BEAT_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef enum logic {ST_IDLE, ST_FILL} rc4_state_e;
endpackage

// File: rtl/rc4_plru.sv
module rc4_plru import rc4_pkg::*; #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  logic [2:0] tree_q [SETS];

  // bit0 picks the half, bit1/bit2 the leaf inside it
  function automatic logic [WAY_W-1:0] leaf(input logic [2:0] t);
    leaf = t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  assign victim_o = leaf(tree_q[rd_idx_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_i) begin
      tree_q[touch_idx_i][0] <= ~touch_way_i[1];
      if (touch_way_i[1]) tree_q[touch_idx_i][2] <= ~touch_way_i[0];
      else                tree_q[touch_idx_i][1] <= ~touch_way_i[0];
    end
  end

  // R7
  plru_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> leaf(tree_q[$past(touch_idx_i)]) != $past(touch_way_i));
endmodule

// File: rtl/rc4_tag_store.sv
module rc4_tag_store import rc4_pkg::*; #(
  parameter int SETS  = 16,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  hit_o,
  output logic [WAYS-1:0]  valid_o,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = wr_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  vld_q <= '0;
      else if (sel) vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[wr_idx_i] <= wr_tag_i;
    end

    assign valid_o[w] = vld_q[lk_idx_i];
    assign hit_o[w]   = vld_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  end

  // R3
  multi_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit_o));
endmodule

// File: rtl/rc4_data_store.sv
module rc4_data_store import rc4_pkg::*; #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int AW    = IDX_W + WAY_W + BEAT_W
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [WORD_W-1:0] mem_q [SETS*WAYS*LINE_WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/rd_cache_4w.sv
module rd_cache_4w import rc4_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_line_addr_o,
  input  logic              mem_beat_valid_i,
  input  logic [WORD_W-1:0] mem_beat_data_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  rc4_state_e        st_q;
  logic [IDX_W-1:0]  r_idx, m_idx_q;
  logic [TAG_W-1:0]  r_tag, m_tag_q;
  logic [BEAT_W-1:0] r_wsel, m_wsel_q, beat_q;
  logic [WAY_W-1:0]  m_way_q, hit_way, inv_way, plru_way, victim;
  logic [WAYS-1:0]   hit_vec, vld_vec;
  logic              hit_any, inv_any, accept, beat_take, fill_last, touch;
  logic [IDX_W-1:0]  touch_idx;
  logic [WAY_W-1:0]  touch_way;
  logic [WORD_W-1:0] rd_data, fill_word_q, rsp_data_q;
  logic              rsp_valid_q, rsp_hit_q;

  assign r_idx  = req_addr_i[OFF_W +: IDX_W];
  assign r_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign r_wsel = req_addr_i[OFF_W-1 -: BEAT_W];

  assign accept    = req_valid_i && (st_q == ST_IDLE);
  assign beat_take = (st_q == ST_FILL) && mem_beat_valid_i;
  assign fill_last = beat_take && (beat_q == BEAT_W'(LINE_WORDS-1));

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way = WAY_W'(w);
      if (!vld_vec[w]) inv_way = WAY_W'(w);
    end
  end
  assign hit_any = |hit_vec;
  assign inv_any = ~&vld_vec;
  assign victim  = inv_any ? inv_way : plru_way;

  assign touch     = (accept && hit_any) || fill_last;
  assign touch_idx = fill_last ? m_idx_q : r_idx;
  assign touch_way = fill_last ? m_way_q : hit_way;

  rc4_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_idx_i(r_idx), .lk_tag_i(r_tag), .hit_o(hit_vec), .valid_o(vld_vec),
    .wr_i(fill_last), .wr_idx_i(m_idx_q), .wr_way_i(m_way_q), .wr_tag_i(m_tag_q)
  );

  rc4_data_store #(.SETS(SETS)) u_data (
    .clk_i,
    .rd_addr_i({r_idx, hit_way, r_wsel}), .rd_data_o(rd_data),
    .wr_i(beat_take), .wr_addr_i({m_idx_q, m_way_q, beat_q}), .wr_data_i(mem_beat_data_i)
  );

  rc4_plru #(.SETS(SETS)) u_plru (
    .clk_i, .rst_ni,
    .rd_idx_i(r_idx), .victim_o(plru_way),
    .touch_i(touch), .touch_idx_i(touch_idx), .touch_way_i(touch_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      m_idx_q     <= '0;
      m_tag_q     <= '0;
      m_wsel_q    <= '0;
      m_way_q     <= '0;
      beat_q      <= '0;
      fill_word_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (hit_any) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b1;
            rsp_data_q  <= rd_data;
          end else begin
            st_q     <= ST_FILL;
            m_idx_q  <= r_idx;
            m_tag_q  <= r_tag;
            m_wsel_q <= r_wsel;
            m_way_q  <= victim;
            beat_q   <= '0;
          end
        end
        ST_FILL: if (beat_take) begin
          beat_q <= beat_q + BEAT_W'(1);
          if (beat_q == m_wsel_q) fill_word_q <= mem_beat_data_i;
          if (fill_last) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= (beat_q == m_wsel_q) ? mem_beat_data_i : fill_word_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_o       = (st_q == ST_FILL);
  assign mem_line_addr_o = {m_tag_q, m_idx_q, {OFF_W{1'b0}}};
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_hit_o       = rsp_hit_q;
  assign rsp_data_o      = rsp_data_q;

  // R3
  hit_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_any) |=> (rsp_valid_o && rsp_hit_o && !mem_req_o));
  // R4
  miss_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_any) |=> (mem_req_o && !req_ready_o && !rsp_valid_o));
  // R5
  fill_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> (rsp_valid_o && !rsp_hit_o));
  // R5
  line_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_line_addr_o));
endmodule

// File: tb/rd_cache_4w_tb_top.sv
`timescale 1ns/1ps
module rd_cache_4w_tb_top;
  localparam int SETS = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_hit_o, mem_req_o;
  logic [31:0] rsp_data_o, mem_line_addr_o;
  logic        mem_beat_valid_i = 1'b0;
  logic [31:0] mem_beat_data_i = '0;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  int       m_tag [SETS][4];
  bit       m_val [SETS][4];
  bit [2:0] m_tree [SETS];

  always #10 clk = ~clk;

  rd_cache_4w #(.ADDR_W(32), .SETS(SETS)) dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .rsp_valid_o, .rsp_hit_o, .rsp_data_o, .mem_req_o, .mem_line_addr_o,
    .mem_beat_valid_i, .mem_beat_data_i
  );

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return (32'(tag) << 9) | (32'(idx) << 5) | (32'(w) << 2);
  endfunction

  function automatic logic [31:0] memword(input logic [31:0] a);
    return ((a >> 2) * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic int ref_victim(input int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    if (m_tree[s][0]) return m_tree[s][2] ? 3 : 2;
    return m_tree[s][1] ? 1 : 0;
  endfunction

  function automatic void ref_touch(input int s, input int w);
    m_tree[s][0] = (w < 2);
    if (w < 2) m_tree[s][1] = (w == 0);
    else       m_tree[s][2] = (w == 2);
  endfunction

  task automatic do_load(input int tag, input int idx, input int w, input int gap, input string rq);
    logic [31:0] a, line;
    int hw;
    a = mk(tag, idx, w);
    line = {a[31:5], 5'b0};
    hw = -1;
    for (int k = 0; k < 4; k++) if (m_val[idx][k] && m_tag[idx][k] == tag) hw = k;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (hw >= 0) begin
      // R3: one-cycle hit response
      chk({rq, "/R3 hit valid"}, 32'(rsp_valid_o), 1);
      chk({rq, "/R3 hit flag"},  32'(rsp_hit_o), 1);
      chk({rq, "/R3 R2 hit data"}, rsp_data_o, memword(a));
      chk({rq, "/R3 no mem req"}, 32'(mem_req_o), 0);
      ref_touch(idx, hw);
    end else begin
      int v;
      v = ref_victim(idx);
      // R4
      chk({rq, "/R4 mem req"}, 32'(mem_req_o), 1);
      chk({rq, "/R4 line addr"}, mem_line_addr_o, line);
      chk({rq, "/R4 stall"}, 32'(req_ready_o), 0);
      for (int b = 0; b < 8; b++) begin
        if (gap > 0 && (b % 3) == 1) begin
          mem_beat_valid_i = 1'b0;
          repeat (gap) @(negedge clk);
          chk({rq, "/R5 gap holds req"}, 32'(mem_req_o), 1);
          chk({rq, "/R5 gap no rsp"}, 32'(rsp_valid_o), 0);
        end
        mem_beat_valid_i = 1'b1;
        mem_beat_data_i  = memword(line | (32'(b) << 2));
        @(negedge clk);
      end
      mem_beat_valid_i = 1'b0;
      chk({rq, "/R5 miss valid"}, 32'(rsp_valid_o), 1);
      chk({rq, "/R5 miss flag"},  32'(rsp_hit_o), 0);
      chk({rq, "/R5 R2 miss data"}, rsp_data_o, memword(a));
      chk({rq, "/R5 req dropped"}, 32'(mem_req_o), 0);
      m_val[idx][v] = 1'b1;
      m_tag[idx][v] = tag;
      ref_touch(idx, v);
    end
    @(negedge clk);
    chk({rq, "/R3 R5 single pulse"}, 32'(rsp_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lfsr;
    for (int s = 0; s < SETS; s++) begin
      m_tree[s] = '0;
      for (int k = 0; k < 4; k++) begin m_val[s][k] = 1'b0; m_tag[s][k] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", 32'(req_ready_o), 1);
    chk("R1 rsp idle", 32'(rsp_valid_o), 0);
    chk("R1 mem idle", 32'(mem_req_o), 0);

    do_load(1, 0, 3, 0, "R1 first miss R6");
    do_load(1, 0, 5, 0, "R2 same line");
    do_load(1, 0, 0, 0, "R2 word0");
    do_load(2, 0, 7, 2, "R6 way1");
    do_load(3, 0, 4, 1, "R6 way2");
    do_load(4, 0, 0, 3, "R6 way3");
    do_load(3, 0, 1, 0, "R7 reorder");
    do_load(1, 0, 2, 0, "R7 reorder");
    do_load(5, 0, 6, 0, "R7 evict");
    do_load(2, 0, 6, 0, "R7 probe");
    do_load(4, 0, 6, 0, "R7 probe");
    do_load(1, 3, 1, 0, "R8 other set");
    do_load(1, 0, 1, 0, "R8 set0 intact");
    do_load(6, 3, 7, 1, "R8 other set fill");

    lfsr = 32'h1ACE;
    for (int i = 0; i < 80; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      do_load(lfsr % 7, (lfsr >> 3) % 2, (lfsr >> 5) % 8, (lfsr >> 8) % 3, "R7 mix");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule